// File: doc/BRIEF.md
# Signed Sequential Multiply-Accumulate Unit

This block forms `y + a*x` for two's-complement operands `a` (multiplicand), `x` (multiplier) and `y` (addend), each `WIDTH` bits wide. It returns a signed result `2*WIDTH` bits wide. It spends one clock cycle on each multiplier bit. A shared product register holds the running partial sum in its upper half and the unconsumed multiplier bits in its lower half. Each cycle it adds the multiplicand into the upper half when the current multiplier bit is set, then shifts the whole register right by one place. The right shift is arithmetic.

The addend costs no extra cycle. It is loaded into the upper half at start, where the right shifts of the following `WIDTH` steps bring it down to its true weight. The multiplier's top bit carries negative weight, so on the final step the multiplicand is subtracted instead of added. The adder works on `WIDTH+1` bits, with both inputs sign-extended. A caller pulses `start` with the operands, waits for the one-cycle `done` pulse, and reads `prod`.

Top module: `seq_smac`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `busy`, `done` and `prod` are all 0.
- R2: A `start` sampled high while `busy` is low captures `a`, `x` and `y` on that clock edge, and `busy` is high in the following cycle.
- R3: `busy` stays high for exactly `WIDTH` cycles. `done` is high for exactly one cycle, namely the first cycle in which `busy` is low again, and it is never high together with `busy`.
- R4: For a multiplier with bit `WIDTH-1` clear, `prod` in the `done` cycle equals `y + a*x`, computed as a signed `2*WIDTH`-bit value with `y` sign-extended.
- R5: For a multiplier with bit `WIDTH-1` set (negative multiplier), `prod` in the `done` cycle equals `y + a*x` as a signed `2*WIDTH`-bit value.
- R6: The most negative multiplicand times the most negative multiplier gives `2^(2*WIDTH-2) + y` exactly, with no wrap.
- R7: A `start` sampled while `busy` is high has no effect. The running operation keeps its operands and still completes `WIDTH` cycles after it was accepted.
- R8: While `busy` is low and no `start` is sampled, `prod` keeps its value, whatever `a`, `x` and `y` do.
- R9: A `start` sampled in the `done` cycle is accepted and begins a new operation at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation; acted on only when idle |
| a | input | WIDTH | Signed multiplicand |
| x | input | WIDTH | Signed multiplier |
| y | input | WIDTH | Signed addend |
| busy | output | 1 | High while the iterations run |
| done | output | 1 | One-cycle completion pulse |
| prod | output | 2*WIDTH | Signed result `y + a*x`, held until the next accepted start |

## Verification
The assertions assume two things about the inputs. First, `a`, `x` and `y` are valid in every cycle where `start` is high. Second, reset is held low across at least one rising edge before the first operation. No assumption is made about `start` arriving while the block is busy: those cycles are checked to be ignored. The bench changes every input only on falling clock edges and always drives operands together with `start`. It deliberately pulses `start` in the middle of a run and in the `done` cycle, and it changes the operand inputs while the block is idle. This exercises the ignore, chaining and hold behaviours without breaking those assumptions.

// File: rtl/smac_pkg.sv
package smac_pkg;

    typedef enum logic {
        SMAC_IDLE = 1'b0,
        SMAC_RUN  = 1'b1
    } smac_state_e;

endpackage

// File: rtl/smac_addsub.sv
// Sign-extended WIDTH+1 bit adder/subtractor for one iteration step.
module smac_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] mcand,
    input  logic             use_m,
    input  logic             neg_m,
    output logic [WIDTH:0]   sum
);
    localparam int EW = WIDTH + 1;

    logic [EW-1:0] acc_ext;
    logic [EW-1:0] m_ext;
    logic [EW-1:0] opnd;
    logic [EW-1:0] cin;

    always_comb begin
        acc_ext = {acc[WIDTH-1], acc};
        m_ext   = {mcand[WIDTH-1], mcand};
        if (!use_m) begin
            opnd = '0;
            cin  = '0;
        end else if (neg_m) begin
            opnd = ~m_ext;
            cin  = {{(EW-1){1'b0}}, 1'b1};
        end else begin
            opnd = m_ext;
            cin  = '0;
        end
        sum = acc_ext + opnd + cin;
    end
endmodule

// File: rtl/smac_ctrl.sv
// Iteration sequencer: accepts start when idle, counts WIDTH steps.
module smac_ctrl
    import smac_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

    typedef struct packed {
        smac_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        load        = 1'b0;
        step        = 1'b0;
        last        = 1'b0;
        case (ctrl_q.state)
            SMAC_IDLE: begin
                if (start) begin
                    load         = 1'b1;
                    ctrl_d.state = SMAC_RUN;
                    ctrl_d.cnt   = '0;
                end
            end
            SMAC_RUN: begin
                step = 1'b1;
                last = (ctrl_q.cnt == LAST_IDX);
                if (last) begin
                    ctrl_d.state = SMAC_IDLE;
                    ctrl_d.cnt   = '0;
                    ctrl_d.done  = 1'b1;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            default: ctrl_d.state = SMAC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: SMAC_IDLE, cnt: '0, done: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy = (ctrl_q.state == SMAC_RUN);
    assign done = ctrl_q.done;
endmodule

// File: rtl/smac_datapath.sv
// Product/multiplier shift register plus held multiplicand.
module smac_datapath #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic               last,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   x,
    input  logic [WIDTH-1:0]   y,
    output logic [2*WIDTH-1:0] prod
);
    localparam int PW = 2 * WIDTH;

    typedef struct packed {
        logic [WIDTH-1:0] hi;
        logic [WIDTH-1:0] lo;
        logic [WIDTH-1:0] mcand;
    } dp_t;

    dp_t dp_d, dp_q;

    logic [WIDTH:0] sum;
    logic           cur_bit;

    assign cur_bit = dp_q.lo[0];

    smac_addsub #(.WIDTH(WIDTH)) addsub_i (
        .acc   (dp_q.hi),
        .mcand (dp_q.mcand),
        .use_m (cur_bit),
        .neg_m (last),
        .sum   (sum)
    );

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.hi    = y;
            dp_d.lo    = x;
            dp_d.mcand = a;
        end else if (step) begin
            dp_d.hi = sum[WIDTH:1];
            dp_d.lo = {sum[0], dp_q.lo[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign prod = PW'({dp_q.hi, dp_q.lo});
endmodule

// File: rtl/seq_smac.sv
// Signed sequential multiply-accumulate: prod = y + a*x after WIDTH steps.
module seq_smac #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   x,
    input  logic [WIDTH-1:0]   y,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] prod
);
    logic load;
    logic step;
    logic last;

    smac_ctrl #(.WIDTH(WIDTH)) ctrl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .last  (last),
        .busy  (busy),
        .done  (done)
    );

    smac_datapath #(.WIDTH(WIDTH)) dp_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .last  (last),
        .a     (a),
        .x     (x),
        .y     (y),
        .prod  (prod)
    );
endmodule

// File: rtl/seq_smac_chk.sv
// Property checker bound to seq_smac.
module seq_smac_chk #(
    parameter int WIDTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [WIDTH-1:0]   a,
    input logic [WIDTH-1:0]   x,
    input logic [WIDTH-1:0]   y,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] prod
);
    localparam int PW    = 2 * WIDTH;
    localparam int RUN_W = $clog2(WIDTH + 2) + 1;

    logic [RUN_W-1:0]     run_len;
    logic signed [PW-1:0] ref_val;
    logic signed [PW-1:0] ref_now;

    assign ref_now = $signed(y) + $signed(a) * $signed(x);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
            ref_val <= '0;
        end else if (start && !busy) begin
            run_len <= '0;
            ref_val <= ref_now;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_fall_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7: a start while busy must neither restart nor stretch the run
    assert_run_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == RUN_W'(WIDTH)));

    assert_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (prod == ref_val));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(prod));
endmodule

bind seq_smac seq_smac_chk #(.WIDTH(WIDTH)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .a     (a),
    .x     (x),
    .y     (y),
    .busy  (busy),
    .done  (done),
    .prod  (prod)
);

// File: tb/seq_smac_tb_top.sv
`timescale 1ns/1ps
module seq_smac_tb_top;
    localparam int W  = 8;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  a = '0;
    logic [W-1:0]  x = '0;
    logic [W-1:0]  y = '0;
    logic          busy;
    logic          done;
    logic [PW-1:0] prod;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    seq_smac #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a(a), .x(x), .y(y),
        .busy(busy), .done(done), .prod(prod)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] model(input logic [W-1:0] av, input logic [W-1:0] xv,
                                              input logic [W-1:0] yv);
        longint r;
        r = longint'($signed(av)) * longint'($signed(xv)) + longint'($signed(yv));
        return r[PW-1:0];
    endfunction

    // called at a falling edge; returns at the following falling edge
    task automatic launch(input logic [W-1:0] av, input logic [W-1:0] xv, input logic [W-1:0] yv);
        a = av; x = xv; y = yv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", busy, 1);
    endtask

    // counts busy cycles until done, then checks length, result and pulse width
    task automatic finish(input logic [PW-1:0] exp, input string req, input int seen);
        int n = seen;
        int guard = 0;
        while (!done && guard < 4 * W) begin
            if (busy) n++;
            guard++;
            @(negedge clk);
        end
        check(n == W, "R3", n, W);
        check(done == 1'b1 && busy == 1'b0, "R3", done, 1);
        check(prod == exp, req, longint'($signed(prod)), longint'($signed(exp)));
    endtask

    task automatic op(input logic [W-1:0] av, input logic [W-1:0] xv, input logic [W-1:0] yv,
                      input string req);
        launch(av, xv, yv);
        finish(model(av, xv, yv), req, 0);
        @(negedge clk);
        check(done == 1'b0, "R3", done, 0);
    endtask

    task automatic test_reset();
        check(busy == 0 && done == 0, "R1", {busy, done}, 0);
        check(prod == '0, "R1", prod, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && done == 0 && prod == '0, "R1", prod, 0);
    endtask

    task automatic test_positive();
        op(8'd3,   8'd5,   8'd0,   "R4");
        op(8'hF9,  8'd13,  8'd100, "R4");
        op(8'd127, 8'd127, 8'd127, "R4");
        op(8'd0,   8'd0,   8'h80,  "R4");
        for (int i = 0; i < 20; i++) begin
            op(W'($urandom), {1'b0, 7'($urandom)}, W'($urandom), "R4");
        end
    endtask

    task automatic test_negative();
        op(8'd7,   8'hFF, 8'd0,  "R5");
        op(8'hFD,  8'hF6, 8'd9,  "R5");
        op(8'd127, 8'h81, 8'h80, "R5");
        for (int i = 0; i < 20; i++) begin
            op(W'($urandom), {1'b1, 7'($urandom)}, W'($urandom), "R5");
        end
    endtask

    task automatic test_extreme();
        op(8'h80, 8'h80, 8'd0,   "R6");
        op(8'h80, 8'h80, 8'd127, "R6");
        op(8'h80, 8'h80, 8'h80,  "R6");
        op(8'h80, 8'd127, 8'h80, "R6");
    endtask

    task automatic test_ignore_start();
        launch(8'd11, 8'hF3, 8'd4);
        a = 8'd99; x = 8'd99; y = 8'd99; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish(model(8'd11, 8'hF3, 8'd4), "R7", 1);
        @(negedge clk);
    endtask

    task automatic test_hold();
        logic [PW-1:0] kept;
        op(8'd21, 8'hEE, 8'd5, "R8");
        kept = prod;
        for (int i = 0; i < 5; i++) begin
            a = W'($urandom); x = W'($urandom); y = W'($urandom);
            @(negedge clk);
        end
        check(prod == kept && !busy, "R8", prod, kept);
    endtask

    task automatic test_chain();
        launch(8'd6, 8'd9, 8'd1);
        finish(model(8'd6, 8'd9, 8'd1), "R4", 0);
        // start raised in the done cycle must be accepted (R9)
        launch(8'hF0, 8'hFA, 8'd2);
        finish(model(8'hF0, 8'hFA, 8'd2), "R9", 0);
        @(negedge clk);
    endtask

    initial begin
        test_reset();
        test_positive();
        test_negative();
        test_extreme();
        test_ignore_start();
        test_hold();
        test_chain();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule